// File: doc/BRIEF.md
# Display Identification Fetch Sequencer

This block pulls the display identification data out of an attached sink and checks it. A single `start` pulse launches an attempt. The block first reads the extension-count byte, which sits at offset 126 of the base block. It then streams the base 128-byte block, one byte per request, and keeps a running modulo-256 sum. When the extension count is nonzero, it also streams exactly one extension block at offset 128. A block is valid only when the sum of all its bytes is zero. The checksum byte of each block, at offset 127, is captured as it passes, so no block is ever buffered.

After the blocks check out, the sequencer reads the sink's test-request register. If the identification-read test bit is set, it writes the checksum byte of the last block read to the test-checksum register, and then writes a fixed response code to the test-response register. Any error response or bad block sum ends the attempt. The whole attempt is repeated, up to a parameter limit, until one succeeds. The result is reported as a one-cycle `done` pulse, a held `pass` flag and the number of attempts used.

All traffic goes through one request port with valid/ready handshaking toward a byte-level transaction engine. The engine acknowledges every request, read or write, with a single-cycle `rsp_valid` that carries `rsp_err` and, for reads, `rsp_data`. The block always accepts a response, so that side has no back-pressure. On the request side, back-pressure is signalled by a low `req_ready`. While `req_valid` is high and `req_ready` is low, all request fields hold. Once a request is accepted, no new request is raised until its response has arrived, and that response comes no earlier than the cycle after acceptance.

Top module: `edid_fetch_seq`

## Requirements
- R1: After reset, `done`, `pass`, `tries` and `req_valid` are all 0.
- R2: A pending request keeps `req_valid` and all its fields steady until `req_ready` is sampled high. Only one request is outstanding at a time. Identification-bus requests carry `req_sink`=0 and `req_dev`=0x50; sink-register requests carry `req_sink`=1 and `req_dev`=0.
- R3: The first request of every attempt is an identification read at address 126, which returns the extension count.
- R4: With extension count 0, the block reads addresses 0..127 in order. With any nonzero count, it reads addresses 0..255 in order and never more.
- R5: If the modulo-256 sum of a block's 128 received bytes is not zero, the attempt ends immediately after that block's last byte.
- R6: A response with `rsp_err`=1, to any read or write, ends the attempt with no further request in that attempt.
- R7: If bit 2 of the test-request byte (sink address 0x218) is 1, the block issues two writes in this order. First it writes the received offset-127 byte of the last block read to sink address 0x261. Then it writes 0x04 to sink address 0x260.
- R8: If that bit is 0, the attempt succeeds with no write issued.
- R9: A failed attempt is retried from R3 until 3 attempts have been made. `done` pulses for exactly one cycle at the end. At that point `pass` shows success, and `tries` holds the number of attempts used (1..3) until the next start.
- R10: `start` has no effect while a fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a fetch (sampled only when idle) |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Engine accepts the request this cycle |
| req_sink | output | 1 | 1 = sink register space, 0 = identification bus |
| req_dev | output | 7 | Identification device address (0x50) or 0 |
| req_wr | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Byte offset or register address |
| req_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_data | input | 8 | Read data |
| rsp_err | input | 1 | Transaction failed |
| done | output | 1 | One-cycle end-of-fetch pulse |
| pass | output | 1 | Last fetch succeeded |
| tries | output | TRY_W | Attempts used by the last fetch |

## Verification
The bench builds the block with its default parameters: 128-byte blocks, a limit of three attempts, a 16-bit address and the test registers at 0x218/0x260/0x261. Keeping the full block length lets the extension-count byte at offset 126 and the checksum byte at offset 127 land where the sink model's images put them. Keeping the limit at three lets a directed case push the attempt counter all the way to its limit, exhaust the retries and finish with a failure. The 16-bit address gives distinct, non-overlapping register addresses. Errors and corrupted bytes are injected by global request index, so a single fault can be placed on the count read, on either block, on the test read or on the second write.

// File: rtl/edid_seq_pkg.sv
package edid_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXT,
    ST_BLK,
    ST_TREQ,
    ST_WCK,
    ST_WRSP
  } seq_st_e;
endpackage

// File: rtl/edid_req_issuer.sv
module edid_req_issuer #(
  parameter int ADDR_W = 16,
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_sink,
  input  logic              go_wr,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [7:0]        go_wdata,
  output logic              busy,
  output logic              fin,
  output logic              fin_err,
  output logic [7:0]        fin_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_sink,
  output logic [6:0]        req_dev,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_err
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      pend_q    <= 1'b0;
      req_sink  <= 1'b0;
      req_wr    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      if (go && !req_valid && !pend_q) begin
        req_valid <= 1'b1;
        req_sink  <= go_sink;
        req_wr    <= go_wr;
        req_addr  <= go_addr;
        req_wdata <= go_wdata;
      end
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        pend_q    <= 1'b1;
      end
      if (pend_q && rsp_valid) pend_q <= 1'b0;
    end
  end

  assign req_dev  = req_sink ? 7'd0 : DEV_ID;
  assign busy     = req_valid || pend_q;
  assign fin      = pend_q && rsp_valid;
  assign fin_err  = rsp_err;
  assign fin_data = rsp_data;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wr)
      && $stable(req_sink) && $stable(req_wdata));

  // R2
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !req_valid);
endmodule

// File: rtl/edid_blk_sum.sv
module edid_blk_sum #(
  parameter int BLK_LEN = 128,
  localparam int IDX_W = $clog2(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_en,
  input  logic [7:0]       byte_in,
  output logic [IDX_W-1:0] idx,
  output logic             last,
  output logic             sum_zero_now,
  output logic [7:0]       cks
);
  logic [7:0] sum_q;

  assign last         = (idx == IDX_W'(BLK_LEN - 1));
  assign sum_zero_now = ((sum_q + byte_in) == 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      idx   <= '0;
      cks   <= '0;
    end else begin
      if (byte_en) begin
        sum_q <= sum_q + byte_in;
        idx   <= last ? '0 : idx + 1'b1;
        if (last) cks <= byte_in;
      end
      if (clr) begin
        sum_q <= '0;
        idx   <= '0;
      end
    end
  end

  // R7
  cks_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en && last |=> cks == $past(byte_in));

  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en && last |=> idx == '0);
endmodule

// File: rtl/edid_seq_ctrl.sv
module edid_seq_ctrl
  import edid_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_LEN = 128,
  parameter int MAX_TRIES = 3,
  parameter logic [15:0] TREQ_ADDR = 16'h0218,
  parameter logic [15:0] TCK_ADDR = 16'h0261,
  parameter logic [15:0] TRSP_ADDR = 16'h0260,
  parameter int TEST_BIT = 2,
  parameter logic [7:0] RESP_CODE = 8'h04,
  localparam int IDX_W = $clog2(BLK_LEN),
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic              fin,
  input  logic              fin_err,
  input  logic [7:0]        fin_data,
  input  logic [IDX_W-1:0]  idx,
  input  logic              last,
  input  logic              sum_zero_now,
  input  logic [7:0]        cks,
  output logic              go,
  output logic              go_sink,
  output logic              go_wr,
  output logic [ADDR_W-1:0] go_addr,
  output logic [7:0]        go_wdata,
  output logic              clr,
  output logic              byte_en,
  output logic              done,
  output logic              pass,
  output logic [TRY_W-1:0]  tries
);
  localparam logic [ADDR_W-1:0] EXT_OFS = ADDR_W'(BLK_LEN - 2);

  seq_st_e st_q, nxt;
  logic    wait_q, ext_nz_q, blk1_q;
  logic    att_ok, att_fail, last_try;

  assign last_try = (tries == TRY_W'(MAX_TRIES));
  assign go       = (st_q != ST_IDLE) && !wait_q;
  assign clr      = fin && ((st_q == ST_EXT) || (st_q == ST_BLK && last));
  assign byte_en  = fin && !fin_err && (st_q == ST_BLK);

  always_comb begin
    go_sink  = 1'b0;
    go_wr    = 1'b0;
    go_addr  = '0;
    go_wdata = '0;
    case (st_q)
      ST_EXT:  go_addr = EXT_OFS;
      ST_BLK:  go_addr = ADDR_W'(idx) + (blk1_q ? ADDR_W'(BLK_LEN) : ADDR_W'(0));
      ST_TREQ: begin go_sink = 1'b1; go_addr = ADDR_W'(TREQ_ADDR); end
      ST_WCK:  begin go_sink = 1'b1; go_wr = 1'b1; go_addr = ADDR_W'(TCK_ADDR); go_wdata = cks; end
      ST_WRSP: begin go_sink = 1'b1; go_wr = 1'b1; go_addr = ADDR_W'(TRSP_ADDR); go_wdata = RESP_CODE; end
      default: ;
    endcase
  end

  always_comb begin
    att_ok   = 1'b0;
    att_fail = 1'b0;
    nxt      = st_q;
    if (fin) begin
      if (fin_err) att_fail = 1'b1;
      else begin
        case (st_q)
          ST_EXT: nxt = ST_BLK;
          ST_BLK: if (last) begin
            if (!sum_zero_now) att_fail = 1'b1;
            else if (!blk1_q && ext_nz_q) nxt = ST_BLK;
            else nxt = ST_TREQ;
          end
          ST_TREQ: if (fin_data[TEST_BIT]) nxt = ST_WCK; else att_ok = 1'b1;
          ST_WCK:  nxt = ST_WRSP;
          ST_WRSP: att_ok = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wait_q   <= 1'b0;
      ext_nz_q <= 1'b0;
      blk1_q   <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
      tries    <= '0;
    end else begin
      done <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start) begin
          st_q   <= ST_EXT;
          tries  <= TRY_W'(1);
          pass   <= 1'b0;
          wait_q <= 1'b0;
        end
      end else begin
        if (go) wait_q <= 1'b1;
        if (fin) begin
          wait_q <= 1'b0;
          if (st_q == ST_EXT && !fin_err) begin
            ext_nz_q <= (fin_data != 8'h00);
            blk1_q   <= 1'b0;
          end
          if (st_q == ST_BLK && last && !fin_err) blk1_q <= 1'b1;
          if (att_ok) begin
            st_q <= ST_IDLE;
            pass <= 1'b1;
            done <= 1'b1;
          end else if (att_fail) begin
            if (last_try) begin
              st_q <= ST_IDLE;
              done <= 1'b1;
            end else begin
              tries <= tries + 1'b1;
              st_q  <= ST_EXT;
            end
          end else st_q <= nxt;
        end
      end
    end
  end

  // R9
  one_shot_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tries >= TRY_W'(1)) && (tries <= TRY_W'(MAX_TRIES)));

  // R6
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin && fin_err |=> (st_q == ST_EXT) || (st_q == ST_IDLE));

  // R2
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

  // R7
  wck_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_WRSP) |-> $past(st_q) == ST_WCK);
endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq #(
  parameter int ADDR_W = 16,
  parameter int BLK_LEN = 128,
  parameter int MAX_TRIES = 3,
  parameter logic [6:0] DEV_ID = 7'h50,
  parameter logic [15:0] TREQ_ADDR = 16'h0218,
  parameter logic [15:0] TCK_ADDR = 16'h0261,
  parameter logic [15:0] TRSP_ADDR = 16'h0260,
  parameter int TEST_BIT = 2,
  parameter logic [7:0] RESP_CODE = 8'h04,
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_sink,
  output logic [6:0]        req_dev,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_err,
  output logic              done,
  output logic              pass,
  output logic [TRY_W-1:0]  tries
);
  localparam int IDX_W = $clog2(BLK_LEN);

  logic              go, go_sink, go_wr, busy, fin, fin_err;
  logic [ADDR_W-1:0] go_addr;
  logic [7:0]        go_wdata, fin_data, cks;
  logic              clr, byte_en, last, sum_zero_now;
  logic [IDX_W-1:0]  idx;

  edid_req_issuer #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_iss (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_sink(go_sink), .go_wr(go_wr), .go_addr(go_addr), .go_wdata(go_wdata),
    .busy(busy), .fin(fin), .fin_err(fin_err), .fin_data(fin_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_sink(req_sink), .req_dev(req_dev),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  edid_blk_sum #(.BLK_LEN(BLK_LEN)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(clr), .byte_en(byte_en), .byte_in(fin_data),
    .idx(idx), .last(last), .sum_zero_now(sum_zero_now), .cks(cks)
  );

  edid_seq_ctrl #(
    .ADDR_W(ADDR_W), .BLK_LEN(BLK_LEN), .MAX_TRIES(MAX_TRIES),
    .TREQ_ADDR(TREQ_ADDR), .TCK_ADDR(TCK_ADDR), .TRSP_ADDR(TRSP_ADDR),
    .TEST_BIT(TEST_BIT), .RESP_CODE(RESP_CODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .fin(fin), .fin_err(fin_err), .fin_data(fin_data),
    .idx(idx), .last(last), .sum_zero_now(sum_zero_now), .cks(cks),
    .go(go), .go_sink(go_sink), .go_wr(go_wr), .go_addr(go_addr), .go_wdata(go_wdata),
    .clr(clr), .byte_en(byte_en),
    .done(done), .pass(pass), .tries(tries)
  );
endmodule

// File: tb/edid_fetch_seq_bench.sv
module edid_fetch_seq_bench;
  localparam int AW = 16;
  localparam int TREQ = 16'h0218;
  localparam int TCK = 16'h0261;
  localparam int TRSP = 16'h0260;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req_valid, req_ready, req_sink, req_wr;
  logic [6:0] req_dev;
  logic [AW-1:0] req_addr;
  logic [7:0] req_wdata;
  logic rsp_valid, rsp_err;
  logic [7:0] rsp_data;
  logic done, pass;
  logic [1:0] tries;

  always #10 clk = ~clk;

  edid_fetch_seq u_edid_fetch_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_sink(req_sink), .req_dev(req_dev),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .done(done), .pass(pass), .tries(tries)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sink model state
  logic [7:0] img [0:255];
  logic [7:0] treq_v;
  int err_at, bad0, bad1;
  int g_n, proto_err;
  bit g_sink [0:1023];
  bit g_wr [0:1023];
  int g_addr [0:1023];
  int g_dev [0:1023];
  logic [7:0] g_wd [0:1023];
  bit pend_m, prev_stall;
  int dly;
  logic [7:0] nxt_d;
  bit nxt_e;
  logic [AW-1:0] s_addr;
  logic [7:0] s_wd;
  logic s_wr, s_sink;

  function automatic logic [7:0] flip(input int k, input logic [7:0] v);
    return v ^ (((k == bad0) || (k == bad1)) ? 8'h01 : 8'h00);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = 8'h00; rsp_err = 1'b0;
      pend_m = 1'b0; prev_stall = 1'b0; dly = 0;
    end else begin
      rsp_valid = 1'b0;
      rsp_err = 1'b0;
      if (prev_stall && !(req_valid && req_addr == s_addr && req_wr == s_wr &&
                          req_sink == s_sink && req_wdata == s_wd)) proto_err++;
      if (pend_m && req_valid) proto_err++;
      if (pend_m) begin
        req_ready = 1'b0;
        if (dly == 0) begin
          rsp_valid = 1'b1; rsp_data = nxt_d; rsp_err = nxt_e; pend_m = 1'b0;
        end else dly--;
      end else begin
        req_ready = ($urandom % 4) != 0;
        if (req_valid && req_ready) begin
          if (g_n < 1024) begin
            g_sink[g_n] = req_sink; g_wr[g_n] = req_wr; g_addr[g_n] = int'(req_addr);
            g_dev[g_n] = int'(req_dev); g_wd[g_n] = req_wdata;
          end
          if (req_wr) nxt_d = 8'h00;
          else if (req_sink) nxt_d = flip(g_n, treq_v);
          else nxt_d = flip(g_n, img[req_addr[7:0]]);
          nxt_e = (g_n == err_at);
          g_n++;
          pend_m = 1'b1;
          dly = $urandom % 3;
        end
      end
      prev_stall = req_valid && !req_ready;
      s_addr = req_addr; s_wr = req_wr; s_sink = req_sink; s_wd = req_wdata;
    end
  end

  // expected-sequence builder
  bit e_sink [0:1023];
  bit e_wr [0:1023];
  int e_addr [0:1023];
  logic [7:0] e_wd [0:1023];
  int e_n, e_tries;
  bit e_pass;

  task automatic push(input bit s, input bit w, input int a, input logic [7:0] d);
    e_sink[e_n] = s; e_wr[e_n] = w; e_addr[e_n] = a; e_wd[e_n] = d; e_n++;
  endtask

  task automatic attempt(output bit ok);
    int k, nb;
    logic [7:0] v, s, ck, t;
    ok = 0;
    ck = 0;
    k = e_n; push(0, 0, 126, 0);
    if (k == err_at) return;
    nb = (flip(k, img[126]) != 0) ? 2 : 1;
    for (int b = 0; b < nb; b++) begin
      s = 0;
      for (int i = 0; i < 128; i++) begin
        k = e_n; push(0, 0, b*128 + i, 0);
        if (k == err_at) return;
        v = flip(k, img[b*128 + i]);
        s = s + v;
        if (i == 127) ck = v;
      end
      if (s != 0) return;
    end
    k = e_n; push(1, 0, TREQ, 0);
    if (k == err_at) return;
    t = flip(k, treq_v);
    if (t[2]) begin
      k = e_n; push(1, 1, TCK, ck);
      if (k == err_at) return;
      k = e_n; push(1, 1, TRSP, 8'h04);
      if (k == err_at) return;
    end
    ok = 1;
  endtask

  task automatic build_expect();
    bit ok;
    e_n = 0; e_pass = 0; e_tries = 0;
    for (int a = 1; a <= 3; a++) begin
      e_tries = a;
      attempt(ok);
      if (ok) begin e_pass = 1; break; end
    end
  endtask

  task automatic make_image(input int ext, input bit tbit);
    logic [7:0] s;
    for (int i = 0; i < 256; i++) img[i] = 8'($urandom);
    img[126] = 8'(ext);
    for (int b = 0; b < 2; b++) begin
      s = 0;
      for (int i = 0; i < 127; i++) s = s + img[b*128 + i];
      img[b*128 + 127] = 8'h00 - s;
    end
    treq_v = (8'($urandom) & 8'hFB) | (tbit ? 8'h04 : 8'h00);
  endtask

  task automatic run_test(input int ext, input bit tbit, input int ea, input int b0,
                          input int b1, input bit mid_start, input string tag);
    int cyc, mism, got_tries;
    bit seen, got_pass;
    make_image(ext, tbit);
    err_at = ea; bad0 = b0; bad1 = b1;
    build_expect();
    g_n = 0; proto_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 0; got_pass = 0; got_tries = 0;
    for (cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (mid_start && cyc == 50) start = 1'b1;
      if (mid_start && cyc == 51) start = 1'b0;
      if (done) begin seen = 1; got_pass = pass; got_tries = int'(tries); break; end
    end
    chk(seen, {tag, " R9 done seen (watchdog)"}, seen, 1);
    if (!seen) return;
    @(negedge clk);
    chk(!done, {tag, " R9 done one cycle"}, done, 0);
    chk(got_pass == e_pass, {tag, " R9 pass"}, got_pass, e_pass);
    chk(got_tries == e_tries, {tag, " R9 tries"}, got_tries, e_tries);
    chk(int'(tries) == e_tries && pass == e_pass, {tag, " R9 result held"}, int'(tries), e_tries);
    chk(proto_err == 0, {tag, " R2 handshake"}, proto_err, 0);
    chk(g_n == e_n, {tag, " request count"}, g_n, e_n);
    mism = -1;
    for (int i = 0; i < e_n && i < g_n; i++) begin
      if (g_sink[i] != e_sink[i] || g_wr[i] != e_wr[i] || g_addr[i] != e_addr[i] ||
          g_dev[i] != (e_sink[i] ? 0 : 'h50) || (e_wr[i] && g_wd[i] != e_wd[i])) begin
        mism = i; break;
      end
    end
    chk(mism < 0, {tag, " request sequence first mismatch"}, mism, -1);
    chk(g_n > 0 && g_addr[0] == 126 && !g_sink[0], {tag, " R3 first read"},
        (g_n > 0) ? g_addr[0] : -1, 126);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    err_at = -1; bad0 = -1; bad1 = -1; treq_v = 0; g_n = 0; proto_err = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !pass && tries == 0 && !req_valid, "R1 reset outputs",
        {done, pass, tries, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !done, "R1 idle after reset", req_valid, 0);

    run_test(0, 0, -1, -1, -1, 0, "R4 R8 no-extension clean");
    run_test(2, 1, -1, -1, -1, 0, "R4 R7 extension with test write");
    run_test(0, 1, -1, -1, -1, 0, "R7 base-block test write");
    run_test(1, 0, -1, 10, -1, 0, "R5 bad base sum retried");
    run_test(1, 0, -1, 132, -1, 0, "R5 bad extension sum retried");
    run_test(0, 0, 0, -1, -1, 0, "R6 error on count read");
    run_test(0, 1, 131, -1, -1, 0, "R6 error on response write");
    run_test(0, 0, 260, 5, 135, 0, "R9 three failures");
    run_test(3, 1, -1, -1, -1, 1, "R10 start while busy");
    for (int t = 0; t < 8; t++) begin
      int ext, ea, b0;
      ext = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 3);
      ea = ($urandom % 4 == 0) ? int'($urandom % 300) : -1;
      b0 = ($urandom % 4 == 0) ? int'($urandom % 300) : -1;
      run_test(ext, 1'($urandom), ea, b0, -1, 0, "R4 R6 R7 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(190000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule